// File: doc/BRIEF.md
# Trainable Two-Input Spiking Network Sequencer

This block holds a small two-layer spiking network. Two input spike lines feed a hidden layer of `NHID` leaky accumulate-and-fire neurons, and the hidden spikes feed `NOUT` output neurons. A three-state controller steps the network through discrete time samples. Every neuron keeps a fixed-point membrane potential. In each sample it adds the weights of its active inputs to half of its previous potential. It fires when the result reaches the threshold, and it loses half a unit of potential when it fires.

When training is on, the output neurons learn from the target spikes. The hidden neurons learn from teacher spikes that the block derives from the output error. Every weight update uses shifts, adds and subtracts only. The sample index steps through `NPAT` patterns; the bench uses the four XOR cases. The epoch counter advances each time the index wraps. A done flag reports whether the last full epoch ran in training mode with every output matching its target.

The controller has three states:
- ST_IDLE (S0): entered at reset, held until `start`.
- ST_STEP: one sample is evaluated and the network state is registered.
- ST_NEXT: the sample index, epoch and done flag are updated.

The transitions are: idle-to-step on `start`, step-to-next always, and next-to-step always.

Top module: `snn_train_ctrl`

## Requirements
- R1: During and after reset, `y_out`, `smp_idx`, `epoch` and `done` are all zero. Every membrane potential and every trace is zero.
- R2: In ST_IDLE, with `start` low, nothing changes at the ports, whatever `x_in`, `t_in` and `train_en` are. `start` has no effect once the controller has left ST_IDLE.
- R3: The clock edge that sees `start` in ST_IDLE moves the controller to ST_STEP. After that, ST_STEP and ST_NEXT alternate, so each sample takes two cycles. `y_out` is loaded only at the edge that ends ST_STEP. `smp_idx` is updated only at the edge that ends ST_NEXT.
- R4: Values are signed Q5.12 (17 bits, 1.0 = 4096). Let acc = (V >>> 1) + sum of the weights whose input spike is 1, and u = acc − 1024. The neuron spikes when u >= 0. The new V is acc − 2048 if it spiked, else acc, saturated to 17 bits. Output neuron k drives `y_out[k]`.
- R5: With `train_en` low at the edge that ends ST_STEP, no weight changes.
- R6: Each neuron keeps one trace per input: H = (H >>> 1) + 4096·x, updated in every step. With training on, a weight changes only when −2048 <= u < 2048 and the spike differs from the neuron's teacher. The weight then loses (H >>> 4) if the neuron spiked, or gains (H >>> 4) if it did not, saturated to 17 bits.
- R7: The teacher of hidden neuron n is 1 when (4096·spike_n − D_n) >= 2048. D_n sums, over the output neurons k that are inside the window with spike_k ≠ t_in[k], +W_kn if spike_k = 1 and −W_kn otherwise. D_n uses the output weights from before the update.
- R8: `smp_idx` counts 0 to NPAT−1 and wraps to 0. Each wrap increments the 10-bit `epoch`, which rolls over from 1023 to 0.
- R9: At each wrap, `done` takes 1 if every step of the finished epoch had `train_en` high and `y_out` equal to `t_in`. Otherwise it takes 0. It holds between wraps.
- R10: The weight from input i of neuron g starts at (((5g + 3i + 2) mod 7) − 3)·1024. Hidden neurons are numbered g = 0 to NHID−1, and output neuron k is g = NHID + k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Leaves ST_IDLE |
| train_en | input | 1 | 1: infer and train, 0: infer only |
| x_in | input | 2 | Input spike pair for the current sample |
| t_in | input | NOUT | Target spikes for the output neurons |
| y_out | output | NOUT | Registered output spikes |
| smp_idx | output | $clog2(NPAT) | Current sample index |
| epoch | output | EPW (10) | Completed-epoch count |
| done | output | 1 | Last epoch fully matched in training mode |

## Verification
`start` is seen at edge 1, and the first sample is evaluated at edge 2. `y_out` for a sample can be read in the half cycle after its ST_STEP edge, and `smp_idx`, `epoch` and `done` in the half cycle after the following ST_NEXT edge. The bench therefore drives each sample at a falling edge, waits one rising edge before comparing `y_out` with a Q5.12 reference model, and waits a second rising edge before comparing the index, epoch and done values. It also confirms that `y_out` did not move across the ST_NEXT edge.

// File: rtl/snn_pkg.sv
`timescale 1ns/1ps
package snn_pkg;
    localparam int WW       = 17;
    localparam int FRAC     = 12;
    localparam int DECAY_SH = 1;
    localparam int ETA_SH   = 4;
    localparam logic signed [WW-1:0] ONE    = 17'sd4096;
    localparam logic signed [WW-1:0] THETA  = 17'sd1024;
    localparam logic signed [WW-1:0] P_DROP = 17'sd2048;
    localparam logic signed [WW-1:0] HALF   = 17'sd2048;
    localparam logic signed [WW-1:0] GWIN   = 17'sd2048;

    typedef enum logic [1:0] {ST_IDLE, ST_STEP, ST_NEXT} ctl_state_t;

    // starting weight of input i on neuron g
    function automatic logic signed [WW-1:0] init_w(input int g, input int i);
        return WW'((((g * 5 + i * 3 + 2) % 7) - 3) * 1024);
    endfunction
endpackage

// File: rtl/sam_neuron.sv
`timescale 1ns/1ps
module sam_neuron
    import snn_pkg::*;
#(
    parameter int NIN = 2,
    parameter int GID = 0
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  logic                    train,
    input  logic [NIN-1:0]          x,
    input  logic                    tgt,
    output logic                    spk,
    output logic                    grad_on,
    output logic [NIN-1:0][WW-1:0]  w
);
    localparam int ACCW = WW + $clog2(NIN + 1) + 2;
    localparam logic signed [ACCW-1:0] WMAX = ACCW'((2 ** (WW - 1)) - 1);
    localparam logic signed [ACCW-1:0] WMIN = ACCW'(-(2 ** (WW - 1)));

    logic signed [WW-1:0]     vq;
    logic [NIN-1:0][WW-1:0]   wq, hq, wnx, hnx;
    logic signed [ACCW-1:0]   acc, urel, vnx, delta;

    function automatic logic [WW-1:0] sat(input logic signed [ACCW-1:0] v);
        if (v > WMAX)      return WMAX[WW-1:0];
        else if (v < WMIN) return WMIN[WW-1:0];
        else               return v[WW-1:0];
    endfunction

    // potential and firing
    always_comb begin
        acc = ACCW'(vq >>> DECAY_SH);
        for (int i = 0; i < NIN; i++)
            if (x[i]) acc = acc + ACCW'($signed(wq[i]));
        urel    = acc - ACCW'(THETA);
        spk     = ~urel[ACCW-1];
        grad_on = (urel >= -ACCW'(GWIN)) && (urel < ACCW'(GWIN));
        vnx     = spk ? acc - ACCW'(P_DROP) : acc;
    end

    // traces and weight update
    always_comb begin
        delta = '0;
        for (int i = 0; i < NIN; i++) begin
            hnx[i] = WW'(($signed(hq[i]) >>> DECAY_SH) + (x[i] ? ONE : 17'sd0));
            delta  = ACCW'($signed(hnx[i]) >>> ETA_SH);
            if (train && grad_on && spk && !tgt)
                wnx[i] = sat(ACCW'($signed(wq[i])) - delta);
            else if (train && grad_on && !spk && tgt)
                wnx[i] = sat(ACCW'($signed(wq[i])) + delta);
            else
                wnx[i] = wq[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vq <= '0;
            hq <= '0;
            for (int i = 0; i < NIN; i++) wq[i] <= init_w(GID, i);
        end else if (step) begin
            vq <= sat(vnx);
            hq <= hnx;
            wq <= wnx;
        end
    end

    assign w = wq;

    // R5
    infer_keep_w_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !train) |=> $stable(wq));
    // R6
    idle_keep_w_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(wq) && $stable(hq)));
endmodule

// File: rtl/snn_seq_ctrl.sv
`timescale 1ns/1ps
module snn_seq_ctrl
    import snn_pkg::*;
#(
    parameter int NPAT = 4,
    parameter int EPW  = 10,
    parameter int IW   = $clog2(NPAT)
)(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           train,
    input  logic           match,
    output logic           step,
    output logic [IW-1:0]  idx,
    output logic [EPW-1:0] epoch,
    output logic           done
);
    ctl_state_t st, st_nx;
    logic       ok;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (start) st_nx = ST_STEP;
            ST_STEP: st_nx = ST_NEXT;
            ST_NEXT: st_nx = ST_STEP;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    assign step = (st == ST_STEP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx   <= '0;
            epoch <= '0;
            done  <= 1'b0;
            ok    <= 1'b1;
        end else begin
            unique case (st)
                ST_STEP: ok <= ok & match & train;
                ST_NEXT: begin
                    if (idx == IW'(NPAT - 1)) begin
                        idx   <= '0;
                        epoch <= epoch + 1'b1;
                        done  <= ok;
                        ok    <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |=> ($stable(epoch) && $stable(idx) && $stable(done)));
    // R3
    idx_after_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(idx) |-> ($past(st) == ST_NEXT));
    // R3
    step_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !step);
    // R8
    epoch_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(epoch) |-> (idx == '0));
    // R9
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (idx == '0));
endmodule

// File: rtl/snn_train_ctrl.sv
`timescale 1ns/1ps
module snn_train_ctrl
    import snn_pkg::*;
#(
    parameter int NHID = 2,
    parameter int NOUT = 1,
    parameter int NPAT = 4,
    parameter int EPW  = 10,
    parameter int IW   = $clog2(NPAT)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             train_en,
    input  logic [1:0]       x_in,
    input  logic [NOUT-1:0]  t_in,
    output logic [NOUT-1:0]  y_out,
    output logic [IW-1:0]    smp_idx,
    output logic [EPW-1:0]   epoch,
    output logic             done
);
    localparam int DW = WW + $clog2(NOUT + 1) + 2;

    logic                               step;
    logic [NHID-1:0]                    hid_spk, hid_tgt, hid_gd_unused;
    logic [NHID-1:0][1:0][WW-1:0]       hid_w_unused;
    logic [NOUT-1:0]                    out_spk, out_gd, y_q;
    logic [NOUT-1:0][NHID-1:0][WW-1:0]  ow;
    logic signed [DW-1:0]               dsum, hval;

    snn_seq_ctrl #(.NPAT(NPAT), .EPW(EPW), .IW(IW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .train(train_en),
        .match(out_spk == t_in), .step(step), .idx(smp_idx),
        .epoch(epoch), .done(done)
    );

    for (genvar n = 0; n < NHID; n++) begin : g_hid
        sam_neuron #(.NIN(2), .GID(n)) u_h (
            .clk(clk), .rst_n(rst_n), .step(step), .train(train_en),
            .x(x_in), .tgt(hid_tgt[n]), .spk(hid_spk[n]),
            .grad_on(hid_gd_unused[n]), .w(hid_w_unused[n])
        );
    end

    for (genvar k = 0; k < NOUT; k++) begin : g_out
        sam_neuron #(.NIN(NHID), .GID(NHID + k)) u_o (
            .clk(clk), .rst_n(rst_n), .step(step), .train(train_en),
            .x(hid_spk), .tgt(t_in[k]), .spk(out_spk[k]),
            .grad_on(out_gd[k]), .w(ow[k])
        );
    end

    // hidden teacher from back-propagated output error
    always_comb begin
        dsum = '0;
        hval = '0;
        for (int n = 0; n < NHID; n++) begin
            dsum = '0;
            for (int k = 0; k < NOUT; k++)
                if (out_gd[k] && (out_spk[k] != t_in[k]))
                    dsum = out_spk[k] ? dsum + DW'($signed(ow[k][n]))
                                      : dsum - DW'($signed(ow[k][n]));
            hval       = (hid_spk[n] ? DW'(ONE) : DW'(0)) - dsum;
            hid_tgt[n] = (hval >= DW'(HALF));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    y_q <= '0;
        else if (step) y_q <= out_spk;
    end

    assign y_out = y_q;

    // R3
    y_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(y_out) |-> $past(step));
endmodule

// File: tb/tb_snn_train_ctrl.sv
`timescale 1ns/1ps
module tb_snn_train_ctrl;
    localparam int NHID = 2;
    localparam int NOUT = 1;
    localparam int NPAT = 4;
    localparam int EPW  = 10;
    localparam int IW   = 2;
    // {x1, x0, target}
    localparam logic [2:0] XOR_TAB [4] = '{3'b000, 3'b011, 3'b101, 3'b110};

    logic            clk = 1'b0, rst_n = 1'b0, start = 1'b0, train_en = 1'b0;
    logic [1:0]      x_in = '0;
    logic [NOUT-1:0] t_in = '0;
    logic [NOUT-1:0] y_out;
    logic [IW-1:0]   smp_idx;
    logic [EPW-1:0]  epoch;
    logic            done;

    snn_train_ctrl #(.NHID(NHID), .NOUT(NOUT), .NPAT(NPAT), .EPW(EPW), .IW(IW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .train_en(train_en),
        .x_in(x_in), .t_in(t_in), .y_out(y_out), .smp_idx(smp_idx),
        .epoch(epoch), .done(done)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int mw_h [NHID][2], mh_h [NHID][2], mv_h [NHID];
    int mw_o [NOUT][NHID], mh_o [NOUT][NHID], mv_o [NOUT];
    int exp_idx, exp_epoch, exp_done;
    logic [NOUT-1:0] exp_y;
    bit ok_acc;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        if (v > 65535)  return 65535;
        if (v < -65536) return -65536;
        return v;
    endfunction

    function automatic int w0(input int g, input int i);
        return (((g * 5 + i * 3 + 2) % 7) - 3) * 1024;
    endfunction

    task automatic model_reset();
        for (int n = 0; n < NHID; n++) begin
            mv_h[n] = 0;
            for (int i = 0; i < 2; i++) begin mw_h[n][i] = w0(n, i); mh_h[n][i] = 0; end
        end
        for (int k = 0; k < NOUT; k++) begin
            mv_o[k] = 0;
            for (int n = 0; n < NHID; n++) begin mw_o[k][n] = w0(NHID + k, n); mh_o[k][n] = 0; end
        end
        exp_idx = 0; exp_epoch = 0; exp_done = 0; exp_y = '0; ok_acc = 1'b1;
    endtask

    task automatic model_step(input logic [1:0] x, input logic [NOUT-1:0] t, input bit tr);
        int acc, d;
        int hu [NHID], ou [NOUT];
        bit hs [NHID], ht [NHID], os [NOUT], win;
        for (int n = 0; n < NHID; n++) begin
            acc = mv_h[n] >>> 1;
            for (int i = 0; i < 2; i++) if (x[i]) acc += mw_h[n][i];
            hu[n] = acc - 1024; hs[n] = (hu[n] >= 0);
            mv_h[n] = sat(acc - (hs[n] ? 2048 : 0));
        end
        for (int k = 0; k < NOUT; k++) begin
            acc = mv_o[k] >>> 1;
            for (int n = 0; n < NHID; n++) if (hs[n]) acc += mw_o[k][n];
            ou[k] = acc - 1024; os[k] = (ou[k] >= 0);
            mv_o[k] = sat(acc - (os[k] ? 2048 : 0));
        end
        // R7 hidden teacher, old output weights
        for (int n = 0; n < NHID; n++) begin
            d = 0;
            for (int k = 0; k < NOUT; k++)
                if (ou[k] >= -2048 && ou[k] < 2048 && os[k] != t[k])
                    d += os[k] ? mw_o[k][n] : -mw_o[k][n];
            ht[n] = ((hs[n] ? 4096 : 0) - d) >= 2048;
        end
        // R6 traces and updates
        for (int n = 0; n < NHID; n++) begin
            win = (hu[n] >= -2048 && hu[n] < 2048);
            for (int i = 0; i < 2; i++) begin
                mh_h[n][i] = (mh_h[n][i] >>> 1) + (x[i] ? 4096 : 0);
                if (tr && win && hs[n] != ht[n])
                    mw_h[n][i] = sat(hs[n] ? mw_h[n][i] - (mh_h[n][i] >>> 4)
                                           : mw_h[n][i] + (mh_h[n][i] >>> 4));
            end
        end
        for (int k = 0; k < NOUT; k++) begin
            win = (ou[k] >= -2048 && ou[k] < 2048);
            for (int n = 0; n < NHID; n++) begin
                mh_o[k][n] = (mh_o[k][n] >>> 1) + (hs[n] ? 4096 : 0);
                if (tr && win && os[k] != t[k])
                    mw_o[k][n] = sat(os[k] ? mw_o[k][n] - (mh_o[k][n] >>> 4)
                                           : mw_o[k][n] + (mh_o[k][n] >>> 4));
            end
            exp_y[k] = os[k];
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic do_start();
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    // begins and ends at a falling edge
    task automatic run_sample(input logic [1:0] x, input logic [NOUT-1:0] t, input bit tr);
        logic [NOUT-1:0] y_seen;
        x_in = x; t_in = t; train_en = tr;
        @(posedge clk);
        model_step(x, t, tr);
        @(negedge clk);
        check("R4/R6/R7/R10 y_out after step", 32'(y_out), 32'(exp_y));
        ok_acc = ok_acc && (exp_y == t) && tr;
        y_seen = y_out;
        @(posedge clk);
        @(negedge clk);
        if (exp_idx == NPAT - 1) begin
            exp_idx = 0;
            exp_epoch = (exp_epoch + 1) % 1024;
            exp_done = ok_acc;
            ok_acc = 1'b1;
        end else begin
            exp_idx++;
        end
        check("R3 y_out held over next", 32'(y_out), 32'(y_seen));
        check("R3/R8 smp_idx", 32'(smp_idx), 32'(exp_idx));
        check("R8 epoch", 32'(epoch), 32'(exp_epoch));
        check("R9 done", 32'(done), 32'(exp_done));
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        model_reset();
        do_reset();
        // R1 reset state
        check("R1 y_out", 32'(y_out), 0);
        check("R1 smp_idx", 32'(smp_idx), 0);
        check("R1 epoch", 32'(epoch), 0);
        check("R1 done", 32'(done), 0);

        // R2 idle without start
        x_in = 2'b11; t_in = '1; train_en = 1'b1;
        repeat (6) @(negedge clk);
        check("R2 idle y_out", 32'(y_out), 0);
        check("R2 idle smp_idx", 32'(smp_idx), 0);
        check("R2 idle epoch", 32'(epoch), 0);
        check("R2 idle done", 32'(done), 0);

        // table walk: XOR training across the epoch rollover (R8)
        do_start();
        for (int ep = 0; ep < 1030; ep++)
            for (int s = 0; s < NPAT; s++)
                run_sample(XOR_TAB[s][2:1], NOUT'(XOR_TAB[s][0]), 1'b1);
        check("R8 epoch after rollover", 32'(epoch), 6);

        // R5 inference after training: weights frozen in model and design
        for (int ep = 0; ep < 3; ep++)
            for (int s = 0; s < NPAT; s++)
                run_sample(XOR_TAB[s][2:1], NOUT'(XOR_TAB[s][0]), 1'b0);
        check("R9 done after inference epoch", 32'(done), 0);

        // R2 start while running has no effect
        start = 1'b1;
        for (int s = 0; s < NPAT; s++)
            run_sample(XOR_TAB[s][2:1], NOUT'(XOR_TAB[s][0]), 1'b0);
        start = 1'b0;

        // R9 silent pattern trains to a full match
        do_reset();
        do_start();
        for (int s = 0; s < NPAT; s++) run_sample(2'b00, '0, 1'b1);
        check("R9 done after matched training epoch", 32'(done), 1);
        for (int s = 0; s < NPAT; s++) run_sample(2'b00, '0, 1'b0);
        check("R9 done cleared by inference epoch", 32'(done), 0);
        for (int s = 0; s < NPAT; s++) run_sample(2'b00, '1, 1'b1);
        check("R9 done cleared by mismatch epoch", 32'(done), 0);

        // R5 inference from reset matches untrained model
        do_reset();
        do_start();
        for (int ep = 0; ep < 2; ep++)
            for (int s = 0; s < NPAT; s++)
                run_sample(XOR_TAB[s][2:1], NOUT'(XOR_TAB[s][0]), 1'b0);

        summary();
        $finish;
    end
endmodule